// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a processor-driven kick line and flags a stalled processor. Software is expected to flip the kick line from time to time. Either polarity of change restarts an internal cycle counter. If the counter reaches its limit before the line changes again, the active-low watchdog output drops. The output can feed an interrupt input, or it can be looped back externally to a manual reset input.

The counter is also held cleared while the system reset from the reset generator is asserted. The timeout period therefore starts only once that reset releases. A supply-good bit forces the output low whenever the supply is under its threshold, whatever the counter holds. An enable input stands in for the disconnected-kick mode. With the enable low the counter never expires, so the output turns into a plain low-line indicator. The timeout is a parameter in clock cycles.

Top module: `edge_wdog`

## Requirements
- R1: With the enable high, system reset high and no detected kick transition, the output goes low right after the TIMEOUT_CYCLES-th rising clock edge counted from the first edge that samples system reset high. It is still high after the edge before that one.
- R2: A rising or falling change on the kick input clears the counter. The kick passes through a 2-stage synchronizer and is then compared with the previous synchronized sample. Because of this, a timed-out output returns high after the third rising edge following the change, and is still low after the second.
- R3: While system reset is low the counter is held at zero. A timed-out output returns high after the first rising edge that samples system reset low.
- R4: While supply-good is low the output is low in the same cycle, whatever the counter and enable hold.
- R5: While the enable is low the output follows supply-good, and the counter is held at zero. It never expires, however long the kick line stays idle.
- R6: The counter saturates at TIMEOUT_CYCLES and never wraps. Without a clearing event, an expired output stays low indefinitely.
- R7: With the kick toggled every P cycles, the output never goes low for P <= TIMEOUT_CYCLES. It goes low in every period for P >= TIMEOUT_CYCLES + 1.
- R8: The asynchronous reset rst_ni clears the counter and the synchronizer. With supply-good high, the output is high while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_rst_ni | input | 1 | Active-low system reset from the reset generator; clears the timer |
| supply_ok_i | input | 1 | High when the supply is above its reset threshold |
| wd_en_i | input | 1 | Watchdog enable; low models the disconnected-kick mode |
| kick_i | input | 1 | Asynchronous kick line toggled by the processor |
| wd_n_o | output | 1 | Active-low watchdog output |

## Verification
A kick change is felt three rising edges after it is applied: two synchronizer stages, then the edge compare clears the counter. A system-reset or enable clear takes effect after one edge. Expiry lands exactly on the TIMEOUT_CYCLES-th edge after system reset is first sampled high. A supply-good drop shows at the output in the same cycle. The bench drives every input 1 ns after a rising edge and samples after a counted number of edges. For each boundary it checks the value one edge before the due cycle and again on it. A toggle-period sweep from 1 to TIMEOUT_CYCLES+3 is judged only after its start-up intervals have passed, so the two-cycle synchronizer lag on the first interval does not affect the result.

// File: rtl/edge_wdog_pkg.sv
package edge_wdog_pkg;
  // counter width able to hold 0..limit
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/edge_wdog_sync.sv
module edge_wdog_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= 1'b0;
    else         pipe_q[0] <= kick_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= 1'b0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pipe_q[STAGES-1];
  end

  // either polarity counts as a kick
  assign edge_o = pipe_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/edge_wdog_timer.sv
module edge_wdog_timer
  import edge_wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_ni,
  input  logic en_i,
  input  logic edge_i,
  output logic expired_o
);
  localparam int unsigned CW = cnt_width(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          clr;

  assign clr = !sys_rst_ni || edge_i || !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  assert_saturate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT) |=> (cnt_q == LIMIT) || (cnt_q == '0));
  assert_sysrst_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_ni |=> cnt_q == '0);
  assert_edge_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> cnt_q == '0);
  assert_disabled_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !expired_o);
  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr && cnt_q != LIMIT) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/edge_wdog_out.sv
module edge_wdog_out (
  input  logic expired_i,
  input  logic en_i,
  input  logic supply_ok_i,
  output logic wd_n_o
);
  // undervoltage overrides the timer; enable gates expiry at once
  assign wd_n_o = supply_ok_i && !(expired_i && en_i);
endmodule

// File: rtl/edge_wdog.sv
module edge_wdog #(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_ni,
  input  logic supply_ok_i,
  input  logic wd_en_i,
  input  logic kick_i,
  output logic wd_n_o
);
  logic kick_edge;
  logic expired;

  edge_wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  edge_wdog_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_ni (sys_rst_ni),
    .en_i       (wd_en_i),
    .edge_i     (kick_edge),
    .expired_o  (expired)
  );

  edge_wdog_out u_out (
    .expired_i   (expired),
    .en_i        (wd_en_i),
    .supply_ok_i (supply_ok_i),
    .wd_n_o      (wd_n_o)
  );

  always_comb begin
    if (rst_ni && !supply_ok_i) assert_lowline_R4: assert (!wd_n_o);
  end

  assert_disabled_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_en_i && supply_ok_i) |-> wd_n_o);
  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_edge && supply_ok_i && wd_en_i) |=> wd_n_o || !supply_ok_i || !wd_en_i);
endmodule

// File: tb/edge_wdog_tb_top.sv
module edge_wdog_tb_top;
  localparam int unsigned T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic en = 1'b1;
  logic kick = 1'b0;
  logic wd_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  edge_wdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sys_rst_ni  (sys_rst_n),
    .supply_ok_i (supply_ok),
    .wd_en_i     (en),
    .kick_i      (kick),
    .wd_n_o      (wd_n)
  );

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wd_n_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lows;
    #25;
    chk("R8 reset state", wd_n, 1'b1);
    rst_n = 1'b1;
    adv(3);
    chk("R3 held in system reset", wd_n, 1'b1);

    // R1 exact expiry
    sys_rst_n = 1'b1;
    adv(T - 1);
    chk("R1 one edge before timeout", wd_n, 1'b1);
    adv(1);
    chk("R1 at timeout", wd_n, 1'b0);
    adv(3 * T);
    chk("R6 stays low, no wrap", wd_n, 1'b0);

    // R2 rising kick clears
    kick = 1'b1;
    adv(2);
    chk("R2 rise, two edges later still low", wd_n, 1'b0);
    adv(1);
    chk("R2 rise, third edge high", wd_n, 1'b1);
    adv(T + 2);
    chk("R1 re-expiry after kick", wd_n, 1'b0);
    // R2 falling kick clears
    kick = 1'b0;
    adv(2);
    chk("R2 fall, two edges later still low", wd_n, 1'b0);
    adv(1);
    chk("R2 fall, third edge high", wd_n, 1'b1);

    // R3 system reset clears an expired output
    adv(T + 2);
    chk("R3 expired before reset", wd_n, 1'b0);
    sys_rst_n = 1'b0;
    adv(1);
    chk("R3 high one edge after reset", wd_n, 1'b1);
    sys_rst_n = 1'b1;

    // R4 undervoltage while enabled and counting
    adv(2);
    supply_ok = 1'b0;
    #1;
    chk("R4 low in same cycle", wd_n, 1'b0);
    adv(2);
    chk("R4 still low", wd_n, 1'b0);
    supply_ok = 1'b1;
    #1;
    chk("R4 released", wd_n, 1'b1);

    // R5 disable clears an expired output, never expires
    adv(T + 2);
    chk("R5 expired while enabled", wd_n, 1'b0);
    en = 1'b0;
    #1;
    chk("R5 disable releases output", wd_n, 1'b1);
    lows = 0;
    for (int i = 0; i < 4 * T; i++) begin
      adv(1);
      if (wd_n !== 1'b1) lows++;
    end
    n_tests++;
    if (lows != 0) begin
      n_fail++;
      $display("FAIL R5: low samples while disabled=%0d expected 0", lows);
    end
    supply_ok = 1'b0;
    #1;
    chk("R5 low-line while disabled", wd_n, 1'b0);
    supply_ok = 1'b1;
    #1;
    chk("R5 low-line released", wd_n, 1'b1);
    en = 1'b1;
    adv(1);
    chk("R5 re-enabled counts from zero", wd_n, 1'b1);

    // R7 toggle period sweep
    for (int p = 1; p <= int'(T) + 3; p++) begin
      sys_rst_n = 1'b0;
      adv(3);
      sys_rst_n = 1'b1;
      lows = 0;
      for (int k = 0; k < 8; k++) begin
        for (int c = 0; c < p; c++) begin
          adv(1);
          if (k >= 3 && wd_n !== 1'b1) lows++;
        end
        kick = ~kick;
      end
      n_tests++;
      if ((lows > 0) != (p > int'(T))) begin
        n_fail++;
        $display("FAIL R7: period %0d low samples=%0d expected %s", p, lows,
                 (p > int'(T)) ? ">0" : "0");
      end
    end

    // R8 async reset mid-count
    adv(T + 4);
    rst_n = 1'b0;
    #1;
    chk("R8 async reset releases output", wd_n, 1'b1);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule